// File: doc/BRIEF.md
# Audio Dual-Family Divided Clock Generator

This block derives two audio base clocks from four external clock sources. One branch serves the 44.1 kHz family and the other serves the 48 kHz family. Each branch has its own source select and its own divide setting. The divide setting is a power-of-four prescaler followed by a counter. The divided clocks run at a 50 % duty cycle. Each branch also gives a one-cycle pulse on every rising edge of its divided clock. One control bit chooses which branch drives the shared clock output.

A set of per-channel select bytes routes a raw source or a divided clock to each of up to eight serial audio channels. Each channel receives a clock-enable strobe. The whole block runs on one core clock. The four sources arrive as one-cycle tick strobes in that domain, where each tick stands for one source clock edge. Software programs the block through a write-only register port. The address map is: 0 is control, 1 is the 44.1 kHz branch divide, 2 is the 48 kHz branch divide, and 3 + k is channel select register k.

Top module: `audio_brg_clkgen`

## Requirements
- R1: After reset, both divide registers hold 2 and the control and channel select registers hold 0. While reset is held, `clk_out` and every `chan_tick` stay low. With ticks on every cycle, the output then has a period of 6 ticks.
- R2: A divide value has a prescale code in bits 9:8 and a count N in bits 7:0. The prescale codes 0, 1, 2 and 3 give a ratio of 2, 8, 32 and 128. The total division is ratio × (N+1) source ticks.
- R3: A divided clock is high for exactly half its period. It changes level only on a tick of its selected source, and its rising-edge pulse lasts one cycle.
- R4: Source inputs are ordered `src_tick[0]`=A, [1]=B, [2]=C, [3]=I. The source code for the 44.1 kHz branch sits in control bits 22:20 and the code for the 48 kHz branch sits in bits 18:16. In both fields, code 0 selects A, 1 selects B, 2 selects I and 4 selects C. Ticks on the other inputs have no effect.
- R5: When control bit 31 is 0, `clk_out` follows the 44.1 kHz branch. When it is 1, `clk_out` follows the 48 kHz branch.
- R6: A control write changes only bits 31, 22:20 and 18:16. All other written bits are ignored.
- R7: A new divide value is taken up only at the next half-period boundary. The half-period already running completes with the old length.
- R8: In a channel select byte, 0x01 routes A, 0x02 routes B and 0x03 routes C to the channel's strobe. Code 0x10 routes the 44.1 kHz branch pulse and 0x20 routes the 48 kHz branch pulse. Code 0x00 stops the channel.
- R9: An undefined source code (3, 5, 6 or 7) holds its branch low with no pulses. An undefined channel code gives no strobes.
- R10: Channel c uses byte (c mod 4) of select register c/4, which sits at bit offset (c mod 4)×8. Writing one register leaves channels in the other registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| src_tick | input | 4 | Source edge ticks: A, B, C, I in bits 0 to 3 |
| clk_out | output | 1 | Shared divided clock output |
| chan_tick | output | 8 | Per-channel clock-enable strobes |

## Verification
A register write takes effect one cycle after the clock edge that captures it. A divided level changes on the edge that registers the terminal tick, and its pulse rises on that same edge. `chan_tick` follows a raw source tick within the same cycle. All of these settle well before the falling clock edge, so the bench drives every input after the rising edge and samples only on falling edges. Rates are measured in whole periods once the block has settled, and each write is followed by a discarded period. The divide-update check counts falling edges between two rising edges of the output across a write placed three cycles into a half-period, and expects the old half followed by the new half.

// File: rtl/audio_brg_pkg.sv
package audio_brg_pkg;
  localparam int PRE_W = 2;
  localparam int N_W   = 8;
  localparam int DIV_W = PRE_W + N_W;
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(2);

  localparam int OUT_SEL_BIT = 31;
  localparam int SRCA_LSB    = 20;
  localparam int SRCB_LSB    = 16;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DIVA = 3'd1;
  localparam logic [2:0] ADDR_DIVB = 3'd2;
  localparam logic [2:0] ADDR_SEL0 = 3'd3;

  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
  localparam int SRC_C = 2;
  localparam int SRC_I = 3;

  typedef enum logic [2:0] {
    SCODE_A = 3'd0,
    SCODE_B = 3'd1,
    SCODE_I = 3'd2,
    SCODE_C = 3'd4
  } src_code_e;

  localparam logic [7:0] CH_STOP = 8'h00;
  localparam logic [7:0] CH_A    = 8'h01;
  localparam logic [7:0] CH_B    = 8'h02;
  localparam logic [7:0] CH_C    = 8'h03;
  localparam logic [7:0] CH_DIVA = 8'h10;
  localparam logic [7:0] CH_DIVB = 8'h20;

  function automatic logic src_code_ok(input logic [2:0] c);
    return (c == SCODE_A) || (c == SCODE_B) || (c == SCODE_I) || (c == SCODE_C);
  endfunction
endpackage

// File: rtl/abc_reset_sync.sv
module abc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/abc_divider.sv
module abc_divider
  import audio_brg_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [2:0]       src_code,
  input  logic [DIV_W-1:0] cfg,
  output logic             lvl,
  output logic             rise
);
  localparam int MAX_SHIFT = 2 * ((1 << PRE_W) - 1);
  localparam int CNT_W     = N_W + 1 + MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             src_ok, tick_sel, cnt_en, at_term;
  logic [CNT_W-1:0] n_plus1, half_term;
  logic [PRE_W:0]   shamt;

  always_comb begin
    src_ok   = src_code_ok(src_code);
    tick_sel = 1'b0;
    case (src_code)
      SCODE_A: tick_sel = src_tick[SRC_A];
      SCODE_B: tick_sel = src_tick[SRC_B];
      SCODE_I: tick_sel = src_tick[SRC_I];
      SCODE_C: tick_sel = src_tick[SRC_C];
      default: tick_sel = 1'b0;
    endcase
    cnt_en = src_ok & tick_sel;
  end

  always_comb begin
    shamt     = {act_q[DIV_W-1:N_W], 1'b0};
    n_plus1   = CNT_W'(act_q[N_W-1:0]) + CNT_W'(1);
    half_term = (n_plus1 << shamt) - CNT_W'(1);
    at_term   = (cnt_q == half_term);
  end

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    if (!src_ok) begin
      cnt_d = '0;
      lvl_d = 1'b0;
      act_d = cfg;
    end else if (cnt_en) begin
      if (at_term) begin
        cnt_d  = '0;
        lvl_d  = ~lvl_q;
        act_d  = cfg;
        rise_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= DIV_RST;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
    end
  end

  assign lvl  = lvl_q;
  assign rise = rise_q;
endmodule

// File: rtl/abc_chan_route.sv
module abc_chan_route
  import audio_brg_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic [7:0]      sel,
  input  logic [NSRC-1:0] src_tick,
  input  logic            rise_a,
  input  logic            rise_b,
  output logic            tick_out
);
  always_comb begin
    case (sel)
      CH_A:    tick_out = src_tick[SRC_A];
      CH_B:    tick_out = src_tick[SRC_B];
      CH_C:    tick_out = src_tick[SRC_C];
      CH_DIVA: tick_out = rise_a;
      CH_DIVB: tick_out = rise_b;
      default: tick_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/audio_brg_clkgen.sv
module audio_brg_clkgen
  import audio_brg_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int NSRC   = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NSRC-1:0]   src_tick,
  output logic              clk_out,
  output logic [NCH-1:0]    chan_tick
);
  localparam int NSEL = (NCH + 3) / 4;

  logic rst_sync_n;

  abc_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  logic             out_sel_q, out_sel_d;
  logic [2:0]       srca_q, srca_d, srcb_q, srcb_d;
  logic [DIV_W-1:0] diva_q, diva_d, divb_q, divb_d;
  logic             ctrl_we, diva_we, divb_we;
  logic [31:0]      unused_wdata_bits;

  always_comb begin
    ctrl_we   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    diva_we   = wr_en && (wr_addr == ADDR_W'(ADDR_DIVA));
    divb_we   = wr_en && (wr_addr == ADDR_W'(ADDR_DIVB));
    out_sel_d = ctrl_we ? wr_data[OUT_SEL_BIT] : out_sel_q;
    srca_d    = ctrl_we ? wr_data[SRCA_LSB +: 3] : srca_q;
    srcb_d    = ctrl_we ? wr_data[SRCB_LSB +: 3] : srcb_q;
    diva_d    = diva_we ? wr_data[DIV_W-1:0] : diva_q;
    divb_d    = divb_we ? wr_data[DIV_W-1:0] : divb_q;
  end

  assign unused_wdata_bits = wr_data;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_sel_q <= 1'b0;
      srca_q    <= 3'd0;
      srcb_q    <= 3'd0;
      diva_q    <= DIV_RST;
      divb_q    <= DIV_RST;
    end else begin
      out_sel_q <= out_sel_d;
      srca_q    <= srca_d;
      srcb_q    <= srcb_d;
      diva_q    <= diva_d;
      divb_q    <= divb_d;
    end
  end

  logic [NSEL*32-1:0] sel_flat;

  for (genvar k = 0; k < NSEL; k++) begin : g_selreg
    logic [31:0] sel_q, sel_d;
    logic        sel_we;
    always_comb begin
      sel_we = wr_en && (wr_addr == ADDR_W'(int'(ADDR_SEL0) + k));
      sel_d  = sel_we ? wr_data : sel_q;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) sel_q <= '0;
      else             sel_q <= sel_d;
    end
    assign sel_flat[k*32 +: 32] = sel_q;
  end

  logic lvl_a, rise_a, lvl_b, rise_b;

  abc_divider #(.NSRC(NSRC)) u_div_a (
    .clk(clk), .rst_n(rst_sync_n), .src_tick(src_tick), .src_code(srca_q),
    .cfg(diva_q), .lvl(lvl_a), .rise(rise_a)
  );

  abc_divider #(.NSRC(NSRC)) u_div_b (
    .clk(clk), .rst_n(rst_sync_n), .src_tick(src_tick), .src_code(srcb_q),
    .cfg(divb_q), .lvl(lvl_b), .rise(rise_b)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    abc_chan_route #(.NSRC(NSRC)) u_route (
      .sel(sel_flat[(c/4)*32 + (c%4)*8 +: 8]), .src_tick(src_tick),
      .rise_a(rise_a), .rise_b(rise_b), .tick_out(chan_tick[c])
    );
  end

  assign clk_out = out_sel_q ? lvl_b : lvl_a;
endmodule

// File: rtl/audio_brg_clkgen_chk.sv
module audio_brg_clkgen_chk
  import audio_brg_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NSRC = 4,
  parameter int NSEL = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC-1:0]    src_tick,
  input logic               out_sel_q,
  input logic [2:0]         srca_q,
  input logic [2:0]         srcb_q,
  input logic               lvl_a,
  input logic               rise_a,
  input logic               clk_out,
  input logic [NSEL*32-1:0] sel_flat,
  input logic [NCH-1:0]     chan_tick
);
  logic a_ok, b_ok;
  assign a_ok = src_code_ok(srca_q);
  assign b_ok = src_code_ok(srcb_q);

  AST_UNDEF_SRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ok |=> !lvl_a); // R9

  AST_IDLE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ok && (src_tick == '0)) |=> $stable(lvl_a)); // R3

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a |=> !rise_a); // R3

  AST_PULSE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a |-> lvl_a); // R3

  AST_OUT_BRANCH_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel_q && !b_ok) |=> (!clk_out || !out_sel_q)); // R5

  AST_CHAN0_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_flat[7:0] == CH_STOP) |-> !chan_tick[0]); // R8
endmodule

bind audio_brg_clkgen audio_brg_clkgen_chk #(.NCH(NCH), .NSRC(NSRC), .NSEL(NSEL)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .src_tick(src_tick), .out_sel_q(out_sel_q),
  .srca_q(srca_q), .srcb_q(srcb_q), .lvl_a(lvl_a), .rise_a(rise_a),
  .clk_out(clk_out), .sel_flat(sel_flat), .chan_tick(chan_tick)
);

// File: tb/audio_brg_clkgen_tb.sv
`timescale 1ns/1ps
module audio_brg_clkgen_tb;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  src_tick;
  logic        clk_out;
  logic [NCH-1:0] chan_tick;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc = 0;
  logic [3:0] tick_en = 4'hF;
  int tick_per [4] = '{1, 1, 1, 1};
  int ccnt [NCH];

  always #5 clk = ~clk;

  audio_brg_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_tick(src_tick), .clk_out(clk_out), .chan_tick(chan_tick)
  );

  initial begin
    src_tick = '0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      for (int k = 0; k < 4; k++)
        src_tick[k] = tick_en[k] && ((cyc % tick_per[k]) == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && clk_out) return;
      prev = clk_out;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    wait_rise();
    per = 0; hi = 0; prev = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      per++;
      if (clk_out) hi++;
      if (!prev && clk_out) return;
      prev = clk_out;
    end
    per = -1;
  endtask

  task automatic count_rises(input int n, output int r);
    logic prev;
    r = 0; prev = clk_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!prev && clk_out) r++;
      prev = clk_out;
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out) h++;
    end
  endtask

  task automatic count_chan(input int n);
    for (int c = 0; c < NCH; c++) ccnt[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (chan_tick[c]) ccnt[c]++;
    end
  endtask

  function automatic int div_of(input int pre, input int n);
    return (2 << (2 * pre)) * (n + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int per, hi, r, h;
    int nv [4] = '{0, 1, 2, 7};
    int codes [4] = '{0, 1, 2, 4};
    int idxs [4]  = '{0, 1, 3, 2};
    int exp_ch [NCH];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    chk("R1 clk_out in reset", int'(clk_out), 0);
    chk("R1 chan_tick in reset", int'(chan_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    measure(per, hi);
    chk("R1 default period", per, 6);
    chk("R1 default high time", hi, 3);

    // R2/R3 sweep of prescale and count on the 44.1k branch
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j < 4; j++) begin
        wr(3'd1, 32'((p << 8) | nv[j]));
        measure(per, hi);
        measure(per, hi);
        chk("R2 period", per, div_of(p, nv[j]));
        chk("R3 high half", hi, div_of(p, nv[j]) / 2);
      end
    end

    // R5 output branch select
    wr(3'd1, 32'h001);
    wr(3'd2, 32'h005);
    wr(3'd0, 32'h8000_0000);
    measure(per, hi); measure(per, hi);
    chk("R5 bit31=1 uses 48k branch", per, 12);

    // R6 write mask: unmasked bits ignored, masked bits all zero
    wr(3'd0, 32'h7F88_FFFF);
    measure(per, hi); measure(per, hi);
    chk("R6 masked write, R5 bit31=0", per, 4);

    // R4 source codes on the 44.1k branch
    wr(3'd1, 32'h000);
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 32'(codes[s] << 20));
      tick_en = 4'(1 << idxs[s]);
      measure(per, hi); measure(per, hi);
      chk("R4 selected source drives branch", per, 2);
      tick_en = ~(4'(1 << idxs[s]));
      repeat (3) @(negedge clk);
      count_rises(40, r);
      chk("R4 other sources ignored", r, 0);
    end
    wr(3'd0, 32'h8000_0000 | (32'd2 << 16));
    tick_en = 4'b1000;
    measure(per, hi); measure(per, hi);
    chk("R4 48k branch on source I", per, 12);

    // R9 undefined source codes
    tick_en = 4'hF;
    wr(3'd0, 32'd3 << 20);
    repeat (3) @(negedge clk);
    count_high(50, h);
    chk("R9 code 3 holds low", h, 0);
    wr(3'd0, 32'd7 << 20);
    repeat (3) @(negedge clk);
    count_high(50, h);
    chk("R9 code 7 holds low", h, 0);
    wr(3'd0, 32'h8000_0000 | (32'd5 << 16));
    repeat (3) @(negedge clk);
    count_high(50, h);
    chk("R9 code 5 on 48k branch holds low", h, 0);

    // R7 divide change at half-period boundary
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd49);
    measure(per, hi); measure(per, hi);
    begin
      logic prev;
      wait_rise();
      per = 0; prev = 1'b1;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        per++;
        if (per == 3) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd4; end
        if (per == 4) wr_en = 1'b0;
        if (!prev && clk_out) break;
        prev = clk_out;
      end
    end
    chk("R7 old half then new half", per, 55);
    measure(per, hi);
    chk("R7 new period", per, 10);

    // R8/R10 channel routing and packing
    tick_per = '{1, 2, 3, 4};
    tick_en = 4'hF;
    wr(3'd1, 32'h002);
    wr(3'd2, 32'h003);
    wr(3'd3, 32'h1003_0201);
    wr(3'd4, 32'h0255_0020);
    repeat (200) @(negedge clk);
    count_chan(240);
    exp_ch = '{240, 120, 80, 40, 30, 0, 0, 120};
    for (int c = 0; c < NCH; c++)
      chk($sformatf("R8 R10 channel %0d strobes", c), ccnt[c], exp_ch[c]);
    wr(3'd3, 32'h0);
    repeat (5) @(negedge clk);
    count_chan(240);
    exp_ch = '{0, 0, 0, 0, 30, 0, 0, 120};
    for (int c = 0; c < NCH; c++)
      chk($sformatf("R8 stop, R10 isolation, R9 undef code, ch%0d", c), ccnt[c], exp_ch[c]);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule